// File: doc/BRIEF.md
# Switch-Coded Exposure Timer

This block times one exposure for an image sensor sequencer. A slow unit tick comes from an external free-running oscillator at 100 Hz, so one tick is a 10 ms step. A 6-bit exposure code picks the length of the exposure. Its top three bits choose a whole number of seconds and its bottom three bits add a number of milliseconds. The two parts are summed into a count of ticks. A code of all zeros gives the shortest exposure, which is one tick.

The sequencer pulses `start`. At that moment the block takes the exposure code from one of two sources, picked by `use_ext`, and raises `integrate`. The tick input is not related to the system clock. The block synchronises it, counts its rising edges, and after the decoded number of edges pulses `done` for one clock. `integrate` drops on that same cycle. A shutter or light source can follow the `integrate` output directly. The block has no stream data, so every port is a plain control or status pin.

Top module: `exposure_timer`

## Requirements
- R1: While reset is held and right after it, `integrate` and `done` are both 0.
- R2: A `start` pulse seen while `integrate` is 0 drives `integrate` to 1 from the next clock cycle.
- R3: Code bits [5:3] select whole seconds: values 0 to 7 give 0, 1, 2, 3, 4, 5, 7 and 9 s, at 100 ticks per second.
- R4: Code bits [2:0] select added milliseconds: values 0 to 7 give 0, 20, 50, 100, 200, 300, 500 and 800 ms, at 10 ms per tick. The tick count is the sum of the seconds part and the milliseconds part.
- R5: When both fields are 0, the exposure lasts exactly one tick.
- R6: `done` goes high for one cycle after exactly the decoded number of tick rising edges. `integrate` falls on that same cycle and at no other time.
- R7: Only rising edges of the synchronised tick are counted. A tick held high for several clocks counts once.
- R8: When `use_ext` is 1 at `start`, the code comes from `ext_setting`. When it is 0, the code comes from `sw_setting`.
- R9: Changes to either code input while `integrate` is 1 do not change the exposure in progress.
- R10: A `start` pulse while `integrate` is 1 is ignored and does not restart the count.
- R11: Tick edges while idle have no effect: `done` stays 0 and `integrate` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an exposure |
| use_ext | input | 1 | Picks the code source: 1 selects the external lines, 0 selects the switches |
| sw_setting | input | 6 | Exposure code from the switches |
| ext_setting | input | 6 | Exposure code from the external lines |
| unit_tick | input | 1 | Asynchronous 10 ms unit oscillator |
| integrate | output | 1 | High while an exposure is in progress |
| done | output | 1 | One-cycle pulse when the exposure ends |

## Verification
The bench builds the timer with its default parameters: 10 ms per tick and a two-stage synchroniser. The bench drives the tick input itself, a few clocks per tick rather than the real oscillator rate. Even the 980-tick longest exposure then takes only a few thousand cycles. This makes it possible to sweep all 64 exposure codes in full. For every code the bench checks that `done` is absent one tick before the end and arrives exactly at the end. Along the way the sweep varies the tick pulse widths, the code source, code changes in mid-exposure and repeated starts.

// File: rtl/exposure_pkg.sv
package exposure_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} expo_state_t;

  // whole-seconds field lookup (non-linear above 5)
  function automatic int coarse_seconds(input logic [2:0] code);
    case (code)
      3'd6:    return 7;
      3'd7:    return 9;
      default: return int'(code);
    endcase
  endfunction

  // added-milliseconds field lookup
  function automatic int fine_millis(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 20;
      3'd2:    return 50;
      3'd3:    return 100;
      3'd4:    return 200;
      3'd5:    return 300;
      3'd6:    return 500;
      default: return 800;
    endcase
  endfunction

endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= tick_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], tick_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign tick_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/setting_decode.sv
module setting_decode
  import exposure_pkg::*;
#(
  parameter int UNIT_MS = 10,
  parameter int CNT_W   = 10
) (
  input  logic [5:0]       code,
  output logic [CNT_W-1:0] ticks
);
  localparam int UNITS_PER_SEC = 1000 / UNIT_MS;

  int total;

  always_comb begin
    total = coarse_seconds(code[5:3]) * UNITS_PER_SEC
          + fine_millis(code[2:0]) / UNIT_MS;
    if (total == 0) total = 1;
    ticks = CNT_W'(total);
  end
endmodule

// File: rtl/exposure_ctrl.sv
module exposure_ctrl
  import exposure_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_ticks,
  input  logic             tick_rise,
  output logic             integrate,
  output logic             done
);
  expo_state_t      state_q;
  logic [CNT_W-1:0] remain_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            remain_q <= load_ticks;
            state_q  <= ST_RUN;
          end
        end
        default: begin
          if (tick_rise) begin
            if (remain_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              remain_q <= remain_q - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign integrate = (state_q == ST_RUN);
  assign done      = done_q;
endmodule

// File: rtl/exposure_timer.sv
module exposure_timer
  import exposure_pkg::*;
#(
  parameter int UNIT_MS     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       use_ext,
  input  logic [5:0] sw_setting,
  input  logic [5:0] ext_setting,
  input  logic       unit_tick,
  output logic       integrate,
  output logic       done
);
  localparam int MAX_TICKS = 9 * (1000 / UNIT_MS) + 800 / UNIT_MS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [5:0]       code_sel;
  logic [CNT_W-1:0] code_ticks;
  logic             rise;

  assign code_sel = use_ext ? ext_setting : sw_setting;

  tick_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_async(unit_tick),
    .tick_rise (rise)
  );

  setting_decode #(.UNIT_MS(UNIT_MS), .CNT_W(CNT_W)) dec_i (
    .code (code_sel),
    .ticks(code_ticks)
  );

  exposure_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_ticks(code_ticks),
    .tick_rise (rise),
    .integrate (integrate),
    .done      (done)
  );
endmodule

// File: rtl/exposure_timer_chk.sv
module exposure_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic integrate,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!integrate && $past(integrate))); // R6

  AST_FALL_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integrate) |-> done); // R6

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !integrate) |=> integrate); // R2

  AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integrate) |-> $past(start)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!integrate && !done)); // R1
endmodule

bind exposure_timer exposure_timer_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .integrate(integrate),
  .done     (done)
);

// File: tb/exposure_timer_tb_top.sv
`timescale 1ns/1ps
module exposure_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       use_ext = 1'b0;
  logic [5:0] sw_setting = '0;
  logic [5:0] ext_setting = '0;
  logic       unit_tick = 1'b0;
  logic       integrate;
  logic       done;

  int n_chk = 0;
  int n_fail = 0;
  int done_seen = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  exposure_timer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_ext(use_ext),
    .sw_setting(sw_setting), .ext_setting(ext_setting),
    .unit_tick(unit_tick), .integrate(integrate), .done(done)
  );

  always @(posedge clk) begin
    #2;
    if (done) done_seen++;
  end

  function automatic int exp_ticks(input logic [5:0] c);
    int secs, ms, t;
    case (c[5:3])
      3'd0: secs = 0; 3'd1: secs = 1; 3'd2: secs = 2; 3'd3: secs = 3;
      3'd4: secs = 4; 3'd5: secs = 5; 3'd6: secs = 7; default: secs = 9;
    endcase
    case (c[2:0])
      3'd0: ms = 0;   3'd1: ms = 20;  3'd2: ms = 50;  3'd3: ms = 100;
      3'd4: ms = 200; 3'd5: ms = 300; 3'd6: ms = 500; default: ms = 800;
    endcase
    t = secs * 100 + ms / 10;
    return (t == 0) ? 1 : t;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick(input int hi);
    unit_tick = 1'b1;
    repeat (hi) @(negedge clk);
    unit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(integrate), 0);
    check("R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(integrate), 0);

    // idle ticks must do nothing
    done_seen = 0;
    repeat (3) pulse_tick(2);
    repeat (3) @(negedge clk);
    check("R11", done_seen, 0);
    check("R11", int'(integrate), 0);

    for (int s = 0; s < 64; s++) begin
      logic [5:0] code;
      int    n;
      string dtag;
      code = 6'(s);
      n    = exp_ticks(code);
      if (code == 6'd0)          dtag = "R5";
      else if (code[2:0] == 3'd0) dtag = "R3";
      else                       dtag = "R4";
      use_ext = code[0];
      if (code[0]) begin
        ext_setting = code;
        sw_setting  = ~code;
      end else begin
        sw_setting  = code;
        ext_setting = ~code;
      end
      done_seen = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2", int'(integrate), 1);
      for (int k = 1; k < n; k++) begin
        pulse_tick((k % 3 == 0) ? 4 : 1);
        if (k == 1 && s % 8 == 3) begin
          sw_setting  = 6'h3F;
          ext_setting = 6'h3F;
          use_ext     = ~use_ext;
        end
        if (k == 1 && s % 8 == 6) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
      repeat (4) @(negedge clk);
      if (s % 8 == 3)      check("R9", done_seen, 0);
      else if (s % 8 == 6) check("R10", done_seen, 0);
      else if (code[0])    check("R8", done_seen, 0);
      else                 check("R7", done_seen, 0);
      check(dtag, int'(integrate), 1);
      pulse_tick(2);
      repeat (3) @(negedge clk);
      check(code[0] ? "R8" : dtag, done_seen, 1);
      check("R6", int'(integrate), 0);
    end
    finish_run();
  end
endmodule